// File: doc/BRIEF.md
# Stepped-Rate Audio Limiter Gain Control

This block sets the attenuation for a limiter in an audio path. The attenuation is an integer index, and each unit of the index is 0.5 dB. The block is timed by a word-clock tick, which is a one-cycle pulse issued once per stereo sample. An upstream detector supplies a clip flag. While the flag is high, the attenuation rises by one step each time the attack interval has passed. While the flag is low, the attenuation falls by one step each time the release interval has passed.

Both intervals are exponential in their codes. The attack interval is 4^code word-clock periods, and the code is 3 bits wide. The release interval is 16·2^code word-clock periods, and the code is 4 bits wide. An enable input turns the limiter on and off. When the limiter is off, the attenuation is forced to zero. A remedy-select bit is carried to the output next to the index. It tells downstream gain logic whether to act by dropping the bass boost or by lowering the volume.

Top module: `stepped_limiter`

## Requirements
- R1: After reset, `attenIdx` is 0 and `useVolume` is 0.
- R2: With `limEnable`=1 and `clipFlag`=1, `attenIdx` increases by exactly 1 after every 4^`attackCode` consecutive ticks. Code 0 gives 1 tick, code 1 gives 4 ticks, code 2 gives 16 ticks, and code 7 gives 16384 ticks.
- R3: With `limEnable`=1 and `clipFlag`=0, `attenIdx` decreases by exactly 1 after every 16·2^`releaseCode` consecutive ticks. Code 0 gives 16 ticks, code 1 gives 32 ticks, code 10 gives 16384 ticks, and code 15 gives 524288 ticks.
- R4: Only cycles with `wordTick`=1 advance the timers. `attenIdx` changes only on the clock edge that samples a tick, or on an edge where `limEnable`=0.
- R5: `attenIdx` saturates at ATTEN_MAX (63 by default). Further attack steps leave it at that value.
- R6: `attenIdx` never goes below 0. Release expiries at 0 leave it at 0.
- R7: While `limEnable`=0, `attenIdx` is 0 from the next clock edge. Both timers are held at zero, so after re-enabling, a full interval must pass before the first step.
- R8: A change of `clipFlag` restarts the newly selected timer from zero. A full interval must then pass before the first step in the new direction.
- R9: `useVolume` equals the value of `volMode` at the previous clock edge: 0 means remove bass boost, 1 means reduce volume.
- R10: A change of code takes effect at once. If a timer's count is already at or beyond the new interval, the step fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordTick | input | 1 | One-cycle pulse per stereo sample |
| clipFlag | input | 1 | High while the signal is clipping |
| limEnable | input | 1 | Limiter on (1) or off (0) |
| volMode | input | 1 | Remedy select: 0 bass removal, 1 volume reduction |
| attackCode | input | 3 | Attack rate code, 4^code ticks per step |
| releaseCode | input | 4 | Release rate code, 16·2^code ticks per step |
| attenIdx | output | 6 | Attenuation in 0.5 dB steps |
| useVolume | output | 1 | Registered remedy qualifier |

## Verification
Each result appears on the clock edge that samples its cause. A tick that completes an interval updates `attenIdx` on that same edge. Deasserting `limEnable` zeroes the index on the next edge, and `useVolume` follows `volMode` one edge later. The bench changes inputs on falling edges. It raises the tick for the exact number of cycles in an interval, drops it, and then samples at the following falling edge, so every registered update is already visible. The interval boundaries are checked at one tick short of an interval and at exactly one interval.

// File: rtl/limiter_pkg.sv
package limiter_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic clear;
  } limStrobe_t;
endpackage

// File: rtl/lim_timer.sv
module lim_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] lastVal,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  // >= rather than == so a shortened interval never runs away
  assign expire = tick && run && (cnt >= lastVal);

  always_ff @(posedge clk) begin
    if (!rstN || !run) cnt <= '0;
    else if (expire)   cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lim_ctrl.sv
module lim_ctrl
  import limiter_pkg::*;
#(
  parameter int ATK_W = 3,
  parameter int REL_W = 4,
  parameter int CNT_W = 20,
  parameter int REL_BASE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordTick,
  input  logic             clipFlag,
  input  logic             limEnable,
  input  logic [ATK_W-1:0] attackCode,
  input  logic [REL_W-1:0] releaseCode,
  output limStrobe_t       strobe
);
  localparam int ATK_SH_W = ATK_W + 1;

  logic [CNT_W-1:0] atkLast, relLast;
  logic [ATK_SH_W-1:0] atkShift;
  logic atkRun, relRun, atkExpire, relExpire;

  assign atkShift = {attackCode, 1'b0};
  assign atkLast  = (CNT_W'(1) << atkShift) - CNT_W'(1);
  assign relLast  = (CNT_W'(REL_BASE) << releaseCode) - CNT_W'(1);

  assign atkRun = limEnable && clipFlag;
  assign relRun = limEnable && !clipFlag;

  lim_timer #(.CNT_W(CNT_W)) uAtk (
    .clk(clk), .rstN(rstN), .tick(wordTick), .run(atkRun),
    .lastVal(atkLast), .expire(atkExpire)
  );

  lim_timer #(.CNT_W(CNT_W)) uRel (
    .clk(clk), .rstN(rstN), .tick(wordTick), .run(relRun),
    .lastVal(relLast), .expire(relExpire)
  );

  always_comb begin
    strobe.stepUp   = atkExpire;
    strobe.stepDown = relExpire;
    strobe.clear    = !limEnable;
  end
endmodule

// File: rtl/lim_datapath.sv
module lim_datapath
  import limiter_pkg::*;
#(
  parameter int ATTEN_W = 6,
  parameter int ATTEN_MAX = 63
) (
  input  logic               clk,
  input  logic               rstN,
  input  limStrobe_t         strobe,
  input  logic               volMode,
  output logic [ATTEN_W-1:0] attenIdx,
  output logic               useVolume
);
  localparam logic [ATTEN_W-1:0] TOP = ATTEN_W'(ATTEN_MAX);

  logic atTop, atFloor;
  assign atTop   = (attenIdx >= TOP);
  assign atFloor = (attenIdx == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attenIdx  <= '0;
      useVolume <= 1'b0;
    end else begin
      useVolume <= volMode;
      if (strobe.clear)                       attenIdx <= '0;
      else if (strobe.stepUp && !atTop)       attenIdx <= attenIdx + 1'b1;
      else if (strobe.stepDown && !atFloor)   attenIdx <= attenIdx - 1'b1;
    end
  end
endmodule

// File: rtl/stepped_limiter.sv
module stepped_limiter
  import limiter_pkg::*;
#(
  parameter int ATK_W = 3,
  parameter int REL_W = 4,
  parameter int CNT_W = 20,
  parameter int ATTEN_W = 6,
  parameter int ATTEN_MAX = 63
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordTick,
  input  logic               clipFlag,
  input  logic               limEnable,
  input  logic               volMode,
  input  logic [ATK_W-1:0]   attackCode,
  input  logic [REL_W-1:0]   releaseCode,
  output logic [ATTEN_W-1:0] attenIdx,
  output logic               useVolume
);
  limStrobe_t strobe;

  lim_ctrl #(.ATK_W(ATK_W), .REL_W(REL_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wordTick(wordTick), .clipFlag(clipFlag),
    .limEnable(limEnable), .attackCode(attackCode),
    .releaseCode(releaseCode), .strobe(strobe)
  );

  lim_datapath #(.ATTEN_W(ATTEN_W), .ATTEN_MAX(ATTEN_MAX)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .volMode(volMode),
    .attenIdx(attenIdx), .useVolume(useVolume)
  );
endmodule

// File: rtl/lim_chk.sv
module lim_chk #(
  parameter int ATTEN_W = 6,
  parameter int ATTEN_MAX = 63
) (
  input logic               clk,
  input logic               rstN,
  input logic               wordTick,
  input logic               clipFlag,
  input logic               limEnable,
  input logic               volMode,
  input logic [ATTEN_W-1:0] attenIdx,
  input logic               useVolume
);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wordTick && limEnable) |=> $stable(attenIdx));

  // R7
  disable_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !limEnable |=> (attenIdx == '0));

  // R2
  attack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limEnable && clipFlag) |=>
      (attenIdx == $past(attenIdx) || attenIdx == $past(attenIdx) + 1));

  // R3
  release_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limEnable && !clipFlag) |=>
      (attenIdx == $past(attenIdx) || attenIdx + 1 == $past(attenIdx)));

  // R5
  sat_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limEnable && clipFlag && attenIdx == ATTEN_W'(ATTEN_MAX)) |=>
      (attenIdx == ATTEN_W'(ATTEN_MAX)));

  // R6
  floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limEnable && !clipFlag && attenIdx == '0) |=> (attenIdx == '0));

  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(volMode) |=> useVolume);
endmodule

bind stepped_limiter lim_chk #(.ATTEN_W(ATTEN_W), .ATTEN_MAX(ATTEN_MAX)) uChk (
  .clk(clk), .rstN(rstN), .wordTick(wordTick), .clipFlag(clipFlag),
  .limEnable(limEnable), .volMode(volMode), .attenIdx(attenIdx),
  .useVolume(useVolume)
);

// File: tb/sim_stepped_limiter.sv
module sim_stepped_limiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordTick = 1'b0, clipFlag = 1'b0, limEnable = 1'b1, volMode = 1'b0;
  logic [2:0] attackCode = 3'd0;
  logic [3:0] releaseCode = 4'd0;
  logic [5:0] attenIdx;
  logic useVolume;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stepped_limiter u0 (
    .clk(clk), .rstN(rstN), .wordTick(wordTick), .clipFlag(clipFlag),
    .limEnable(limEnable), .volMode(volMode), .attackCode(attackCode),
    .releaseCode(releaseCode), .attenIdx(attenIdx), .useVolume(useVolume)
  );

  // {attack[2:0], release[3:0], clip, ticks[15:0], expected[5:0]}
  localparam int NV = 15;
  localparam logic [29:0] VEC [NV] = '{
    {3'd0, 4'd0, 1'b1, 16'd5,  6'd5},  // R2 code 0
    {3'd1, 4'd0, 1'b1, 16'd8,  6'd7},  // R2 code 1
    {3'd1, 4'd0, 1'b1, 16'd3,  6'd7},  // R2 one short
    {3'd1, 4'd0, 1'b1, 16'd1,  6'd8},  // R2 boundary
    {3'd2, 4'd0, 1'b1, 16'd16, 6'd9},  // R2 code 2
    {3'd2, 4'd0, 1'b0, 16'd15, 6'd9},  // R3 one short
    {3'd2, 4'd0, 1'b0, 16'd1,  6'd8},  // R3 boundary
    {3'd2, 4'd0, 1'b0, 16'd32, 6'd6},  // R3 code 0
    {3'd1, 4'd0, 1'b1, 16'd3,  6'd6},  // R8 attack restarts
    {3'd1, 4'd0, 1'b0, 16'd15, 6'd6},  // R8 release restarts
    {3'd1, 4'd0, 1'b1, 16'd3,  6'd6},  // R8 again
    {3'd1, 4'd0, 1'b1, 16'd1,  6'd7},  // R8 full interval
    {3'd1, 4'd1, 1'b0, 16'd32, 6'd6},  // R3 code 1
    {3'd1, 4'd0, 1'b0, 16'd96, 6'd0},  // R3 down to zero
    {3'd1, 4'd0, 1'b0, 16'd64, 6'd0}   // R6 floor
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wordTick = 1'b1;
    end
    @(negedge clk) wordTick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset atten", attenIdx, 0);
    check("R1 reset useVolume", useVolume, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      attackCode  = VEC[v][29:27];
      releaseCode = VEC[v][26:23];
      clipFlag    = VEC[v][22];
      runTicks(int'(VEC[v][21:6]));
      check($sformatf("R2/R3/R6/R8 vector %0d", v), attenIdx, int'(VEC[v][5:0]));
    end

    // R5 saturation
    attackCode = 3'd0; clipFlag = 1'b1;
    runTicks(70);
    check("R5 saturate", attenIdx, 63);

    // R4 no ticks -> no change
    clipFlag = 1'b0;
    repeat (40) @(negedge clk);
    check("R4 no tick hold", attenIdx, 63);

    // R7 disable
    limEnable = 1'b0;
    @(negedge clk);
    check("R7 disabled zero", attenIdx, 0);
    clipFlag = 1'b1; attackCode = 3'd1;
    runTicks(8);
    check("R7 stays zero with ticks", attenIdx, 0);
    limEnable = 1'b1;
    runTicks(3);
    check("R7 counter cleared", attenIdx, 0);
    runTicks(1);
    check("R7 first step after enable", attenIdx, 1);

    // R10 shortened attack code fires on next tick
    attackCode = 3'd2;
    runTicks(10);
    check("R10 mid count", attenIdx, 1);
    attackCode = 3'd1;
    runTicks(1);
    check("R10 immediate step", attenIdx, 2);

    // R9 mode qualifier
    volMode = 1'b1;
    @(negedge clk);
    check("R9 volume", useVolume, 1);
    volMode = 1'b0;
    @(negedge clk);
    check("R9 bass", useVolume, 0);

    // R3 release code 10 = 16384 ticks
    clipFlag = 1'b0; releaseCode = 4'd10;
    runTicks(16383);
    check("R3 code 10 one short", attenIdx, 2);
    runTicks(1);
    check("R3 code 10 boundary", attenIdx, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule